// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block holds the software-visible control state for a two-channel disk controller's bus-master DMA engine. Each channel has three registers: a run/direction control byte, a status byte, and a 32-bit descriptor-table pointer. All of them sit in one 16-byte, byte-addressed I/O window. Each channel takes an 8-byte slice of that window. Inside a slice, the control byte is at offset 0, the status byte at offset 2 and the pointer at offsets 4 to 7.

Software starts or stops a channel by writing its control byte. The block turns a change of the run bit into a single-cycle start or stop event. The event carries the channel number and the stored descriptor pointer, and the DMA engine acts on it. The engine reports errors and completion interrupts back through per-channel set inputs. Software clears those flags by writing ones. Every access is gated by two enables from the configuration space, one for I/O decode and one for bus mastering. Any access whose width does not suit its register is refused and latched in a sticky error flag.

Top module: `dmar_regs`

## Requirements
- R1: Window offsets 0 to 7 select channel 0 and offsets 8 to 15 select channel 1. Within a slice, the control byte is at offset 0, the status byte at offset 2 and the pointer at offsets 4 to 7 (least significant byte first). Offsets 1 and 3 read as zero.
- R2: After reset, each channel's status byte reads 0x60: the device-0 capable bit (bit 5) and the device-1 capable bit (bit 6) are set. The control byte, the pointer and the sticky error flag read zero.
- R3: A control write that takes the run bit (bit 0) from 0 to 1 sets the status active bit (bit 0). It also pulses `dma_start` for one cycle, in the cycle after the write, with `dma_chan` and `dma_ptr` showing that channel and its pointer. A write that takes the run bit from 1 to 0 clears the active bit and pulses `dma_stop` in the same way. A write that leaves the run bit unchanged gives no pulse.
- R4: While the run bit is already 1, a control write keeps the old direction bit (bit 3). While the run bit is 0, the direction bit takes the written value.
- R5: Software writes never change the status active bit. The capable bits (5 and 6) take the written value, and the other status bits read zero.
- R6: Control and status writes must be 8 bits wide (size code 0). Pointer writes must be 32 bits wide (size code 2) at slice offset 4. Any other write width, and any write at offsets 5 to 7, is refused.
- R7: The pointer stores the written word with bits 1:0 forced to zero.
- R8: While `bm_en` is 0, every write is ignored.
- R9: While `io_en` is 0, every access is ignored. No read response is given, no register changes, and the error flag is not set.
- R10: Reads accept size codes 0 (8 bits), 1 (16 bits, even offset) and 2 (32 bits, offset a multiple of 4). The bytes are assembled little-endian from the window. `rd_valid` and `rd_data` appear in the cycle after the request.
- R11: `dma_err_set` sets status bit 1 and `dma_irq_set` sets status bit 2. A status write with a 1 in either bit clears it, and a 0 leaves it unchanged. A hardware set wins over a clear in the same cycle.
- R12: A refused access width sets the sticky `size_err` flag, which only reset clears. A refused write modifies no register. A refused read still gives `rd_valid` with data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O decode enable; 0 ignores all accesses |
| bm_en | input | 1 | Bus-master enable; 0 ignores all writes |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset in the window |
| bus_size | input | 2 | 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = illegal |
| bus_wdata | input | 32 | Write data, right-justified |
| dma_err_set | input | 2 | Per-channel error flag set |
| dma_irq_set | input | 2 | Per-channel interrupt flag set |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read data, right-justified |
| size_err | output | 1 | Sticky illegal-width flag |
| dma_start | output | 1 | Transfer start pulse |
| dma_stop | output | 1 | Transfer stop pulse |
| dma_chan | output | 1 | Channel of the current pulse |
| dma_ptr | output | 32 | Descriptor pointer of the pulsing channel |

## Verification
Every result of this block comes one register stage after its cause. A read request gives its data, a control write gives its start or stop pulse, and a refused access gives its error flag, all in the cycle after the edge that sampled the request. Status flag sets from the engine also become readable from that cycle. The bench drives each request on a falling edge and holds it for one cycle. It samples the pulses, the read response and the error flag on the next falling edge, so each check lands inside the single cycle its result is due. Effects on registers are then confirmed by a separate read through the window.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    localparam int CH_BYTES = 8;
    localparam int CH_SHIFT = $clog2(CH_BYTES);
    localparam int PTR_W    = 32;

    localparam logic [2:0] OFF_CTL = 3'd0;
    localparam logic [2:0] OFF_ST  = 3'd2;
    localparam logic [2:0] OFF_PTR = 3'd4;

    localparam int CTL_RUN = 0;
    localparam int CTL_DIR = 3;
    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_CAP0 = 5;
    localparam int ST_CAP1 = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic             run;
        logic             dir;
        logic             act;
        logic             err;
        logic             irq;
        logic             cap0;
        logic             cap1;
        logic [PTR_W-1:0] ptr;
        logic             start;
        logic             stop;
    } chan_state_t;

    typedef struct packed {
        logic        rd_valid;
        logic [31:0] rd_data;
        logic        size_err;
    } bus_state_t;

    function automatic logic [7:0] ctl_image(chan_state_t s);
        logic [7:0] b;
        b          = 8'h00;
        b[CTL_RUN] = s.run;
        b[CTL_DIR] = s.dir;
        return b;
    endfunction

    function automatic logic [7:0] st_image(chan_state_t s);
        logic [7:0] b;
        b          = 8'h00;
        b[ST_ACT]  = s.act;
        b[ST_ERR]  = s.err;
        b[ST_IRQ]  = s.irq;
        b[ST_CAP0] = s.cap0;
        b[ST_CAP1] = s.cap1;
        return b;
    endfunction

endpackage

// File: rtl/dmar_decode.sv
module dmar_decode
    import dmar_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4,
    parameter int CHW    = 1
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              io_en,
    input  logic              bm_en,
    output logic [CHW-1:0]    chan,
    output logic              wr_ctl,
    output logic              wr_st,
    output logic              wr_ptr,
    output logic              rd_ok,
    output logic              rd_bad,
    output logic              wr_bad
);

    logic [2:0] off;
    logic       chan_ok;
    logic       acc_rd;
    logic       acc_wr;
    logic       legal_rd;
    logic       legal_wr;

    always_comb begin
        off     = req_addr[2:0];
        chan    = req_addr[ADDR_W-1:CH_SHIFT];
        chan_ok = (int'(chan) < NUM_CH);
        acc_rd  = req_valid && io_en && !req_write;
        acc_wr  = req_valid && io_en && bm_en && req_write;

        unique case (acc_size_e'(req_size))
            SZ_BYTE: legal_rd = 1'b1;
            SZ_HALF: legal_rd = !off[0];
            SZ_WORD: legal_rd = (off[1:0] == 2'b00);
            default: legal_rd = 1'b0;
        endcase

        case (off)
            OFF_CTL, OFF_ST, 3'd1, 3'd3: legal_wr = (acc_size_e'(req_size) == SZ_BYTE);
            OFF_PTR:                     legal_wr = (acc_size_e'(req_size) == SZ_WORD);
            default:                     legal_wr = 1'b0;
        endcase

        rd_ok  = acc_rd && legal_rd && chan_ok;
        rd_bad = acc_rd && !(legal_rd && chan_ok);
        wr_bad = acc_wr && !(legal_wr && chan_ok);
        wr_ctl = acc_wr && legal_wr && chan_ok && (off == OFF_CTL);
        wr_st  = acc_wr && legal_wr && chan_ok && (off == OFF_ST);
        wr_ptr = acc_wr && legal_wr && chan_ok && (off == OFF_PTR);
    end

endmodule

// File: rtl/dmar_chan.sv
module dmar_chan
    import dmar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_st,
    input  logic             wr_ptr,
    input  logic [7:0]       wbyte,
    input  logic [PTR_W-1:0] wword,
    input  logic             err_set,
    input  logic             irq_set,
    output logic [7:0]       ctl_o,
    output logic [7:0]       st_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             start_o,
    output logic             stop_o
);

    chan_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.stop  = 1'b0;

        if (wr_ctl) begin
            if (!s_q.run && wbyte[CTL_RUN]) begin
                s_d.act   = 1'b1;
                s_d.start = 1'b1;
            end else if (s_q.run && !wbyte[CTL_RUN]) begin
                s_d.act  = 1'b0;
                s_d.stop = 1'b1;
            end
            s_d.run = wbyte[CTL_RUN];
            if (!s_q.run) begin
                s_d.dir = wbyte[CTL_DIR];
            end
        end

        if (wr_st) begin
            if (wbyte[ST_ERR]) s_d.err = 1'b0;
            if (wbyte[ST_IRQ]) s_d.irq = 1'b0;
            s_d.cap0 = wbyte[ST_CAP0];
            s_d.cap1 = wbyte[ST_CAP1];
        end

        if (wr_ptr) begin
            s_d.ptr = {wword[PTR_W-1:2], 2'b00};
        end

        if (err_set) s_d.err = 1'b1;
        if (irq_set) s_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cap0 <= 1'b1;
            s_q.cap1 <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_o   = ctl_image(s_q);
    assign st_o    = st_image(s_q);
    assign ptr_o   = s_q.ptr;
    assign start_o = s_q.start;
    assign stop_o  = s_q.stop;

    a_r3_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !ctl_o[CTL_RUN] && wbyte[CTL_RUN]) |=> (start_o && st_o[ST_ACT]));

    a_r3_stop_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && ctl_o[CTL_RUN] && !wbyte[CTL_RUN]) |=> (stop_o && !st_o[ST_ACT]));

    a_r4_dir_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && ctl_o[CTL_RUN]) |=> (ctl_o[CTL_DIR] == $past(ctl_o[CTL_DIR])));

    a_r5_active_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctl) |=> (st_o[ST_ACT] == $past(st_o[ST_ACT])));

    a_r7_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_o[1:0] == 2'b00);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> st_o[ST_ERR]);

endmodule

// File: rtl/dmar_regs.sv
module dmar_regs
    import dmar_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 io_en,
    input  logic                                 bm_en,
    input  logic                                 bus_valid,
    input  logic                                 bus_write,
    input  logic [$clog2(NUM_CH*CH_BYTES)-1:0]   bus_addr,
    input  logic [1:0]                           bus_size,
    input  logic [31:0]                          bus_wdata,
    input  logic [NUM_CH-1:0]                    dma_err_set,
    input  logic [NUM_CH-1:0]                    dma_irq_set,
    output logic                                 rd_valid,
    output logic [31:0]                          rd_data,
    output logic                                 size_err,
    output logic                                 dma_start,
    output logic                                 dma_stop,
    output logic [$clog2(NUM_CH)-1:0]            dma_chan,
    output logic [PTR_W-1:0]                     dma_ptr
);

    localparam int NUM_BYTES = NUM_CH * CH_BYTES;
    localparam int ADDR_W    = $clog2(NUM_BYTES);
    localparam int CHW       = $clog2(NUM_CH);

    logic [CHW-1:0] dec_chan;
    logic           dec_wr_ctl, dec_wr_st, dec_wr_ptr;
    logic           dec_rd_ok, dec_rd_bad, dec_wr_bad;

    logic [7:0]       ctl_v   [NUM_CH];
    logic [7:0]       st_v    [NUM_CH];
    logic [PTR_W-1:0] ptr_v   [NUM_CH];
    logic [NUM_CH-1:0] start_v;
    logic [NUM_CH-1:0] stop_v;

    logic [7:0]  win [NUM_BYTES];
    logic [31:0] rd_word;
    bus_state_t  b_d, b_q;

    dmar_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CHW    (CHW)
    ) u_decode (
        .req_valid (bus_valid),
        .req_write (bus_write),
        .req_addr  (bus_addr),
        .req_size  (bus_size),
        .io_en     (io_en),
        .bm_en     (bm_en),
        .chan      (dec_chan),
        .wr_ctl    (dec_wr_ctl),
        .wr_st     (dec_wr_st),
        .wr_ptr    (dec_wr_ptr),
        .rd_ok     (dec_rd_ok),
        .rd_bad    (dec_rd_bad),
        .wr_bad    (dec_wr_bad)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic hit;
        assign hit = (dec_chan == CHW'(c));

        dmar_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctl  (dec_wr_ctl && hit),
            .wr_st   (dec_wr_st && hit),
            .wr_ptr  (dec_wr_ptr && hit),
            .wbyte   (bus_wdata[7:0]),
            .wword   (bus_wdata),
            .err_set (dma_err_set[c]),
            .irq_set (dma_irq_set[c]),
            .ctl_o   (ctl_v[c]),
            .st_o    (st_v[c]),
            .ptr_o   (ptr_v[c]),
            .start_o (start_v[c]),
            .stop_o  (stop_v[c])
        );

        assign win[c*CH_BYTES + 0] = ctl_v[c];
        assign win[c*CH_BYTES + 1] = 8'h00;
        assign win[c*CH_BYTES + 2] = st_v[c];
        assign win[c*CH_BYTES + 3] = 8'h00;
        for (genvar k = 0; k < 4; k++) begin : g_ptr_byte
            assign win[c*CH_BYTES + 4 + k] = ptr_v[c][8*k +: 8];
        end
    end

    always_comb begin
        int nbytes;
        rd_word = 32'h0;
        unique case (acc_size_e'(bus_size))
            SZ_BYTE: nbytes = 1;
            SZ_HALF: nbytes = 2;
            SZ_WORD: nbytes = 4;
            default: nbytes = 0;
        endcase
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = int'(bus_addr) + k;
            if (k < nbytes && idx < NUM_BYTES) begin
                rd_word[8*k +: 8] = win[idx];
            end
        end
    end

    always_comb begin
        b_d          = b_q;
        b_d.rd_valid = dec_rd_ok || dec_rd_bad;
        b_d.rd_data  = dec_rd_ok ? rd_word : 32'h0;
        b_d.size_err = b_q.size_err || dec_rd_bad || dec_wr_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    always_comb begin
        dma_chan = '0;
        dma_ptr  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (start_v[c] || stop_v[c]) begin
                dma_chan = CHW'(c);
                dma_ptr  = ptr_v[c];
            end
        end
    end

    assign dma_start = |start_v;
    assign dma_stop  = |stop_v;
    assign rd_valid  = b_q.rd_valid;
    assign rd_data   = b_q.rd_data;
    assign size_err  = b_q.size_err;

    a_r12_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |=> size_err);

    a_r12_bad_width_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_rd_bad || dec_wr_bad) |=> size_err);

    a_r8_no_event_without_bm: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bm_en) |=> (!dma_start && !dma_stop));

    a_r9_no_read_without_io: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_valid && io_en)) |=> !rd_valid);

    a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_v, stop_v}));

endmodule

// File: tb/tb_dmar_regs.sv
`timescale 1ns/1ps
module tb_dmar_regs;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_en, bm_en;
    logic        bus_valid, bus_write;
    logic [3:0]  bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [1:0]  dma_err_set, dma_irq_set;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        size_err;
    logic        dma_start, dma_stop;
    logic [0:0]  dma_chan;
    logic [31:0] dma_ptr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        ev_start, ev_stop;
    logic [0:0]  ev_chan;
    logic [31:0] ev_ptr;
    logic        got_valid;
    logic [31:0] got_data;

    always #4 clk = ~clk;

    dmar_regs dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_en       (io_en),
        .bm_en       (bm_en),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_size    (bus_size),
        .bus_wdata   (bus_wdata),
        .dma_err_set (dma_err_set),
        .dma_irq_set (dma_irq_set),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .size_err    (size_err),
        .dma_start   (dma_start),
        .dma_stop    (dma_stop),
        .dma_chan    (dma_chan),
        .dma_ptr     (dma_ptr)
    );

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        ev_start = dma_start; ev_stop = dma_stop; ev_chan = dma_chan; ev_ptr = dma_ptr;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [1:0] sz);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_valid = 1'b0;
        got_valid = rd_valid; got_data = rd_data;
    endtask

    task automatic t_reset();
        check("R2", "size_err after reset", {31'h0, size_err}, 32'h0);
        bus_rd(4'd2, 2'd0);  check("R2", "ch0 status", got_data, 32'h60);
        bus_rd(4'd10, 2'd0); check("R2", "ch1 status", got_data, 32'h60);
        bus_rd(4'd0, 2'd0);  check("R2", "ch0 control", got_data, 32'h00);
        bus_rd(4'd4, 2'd2);  check("R2", "ch0 pointer", got_data, 32'h0);
    endtask

    task automatic t_pointer();
        bus_wr(4'd4, 2'd2, 32'h12345677);
        bus_rd(4'd4, 2'd2);
        check("R7", "pointer alignment", got_data, 32'h12345674);
    endtask

    task automatic t_start();
        bus_wr(4'd0, 2'd0, 32'h09);
        check("R3", "start pulse", {30'h0, ev_start, ev_stop}, 32'h2);
        check("R3", "start channel", {31'h0, ev_chan}, 32'h0);
        check("R3", "start pointer", ev_ptr, 32'h12345674);
        bus_rd(4'd2, 2'd0); check("R3", "active set", got_data, 32'h61);
        bus_rd(4'd0, 2'd0); check("R3", "control after start", got_data, 32'h09);
    endtask

    task automatic t_dir_lock();
        bus_wr(4'd0, 2'd0, 32'h01);
        check("R4", "no pulse on unchanged run", {30'h0, ev_start, ev_stop}, 32'h0);
        bus_rd(4'd0, 2'd0); check("R4", "dir kept while running", got_data, 32'h09);
    endtask

    task automatic t_active_ro();
        bus_wr(4'd2, 2'd0, 32'h00);
        bus_rd(4'd2, 2'd0); check("R5", "active kept, caps cleared", got_data, 32'h01);
        bus_wr(4'd2, 2'd0, 32'h60);
        bus_rd(4'd2, 2'd0); check("R5", "caps rewritten", got_data, 32'h61);
    endtask

    task automatic t_stop();
        bus_wr(4'd0, 2'd0, 32'h00);
        check("R3", "stop pulse", {30'h0, ev_start, ev_stop}, 32'h1);
        check("R3", "stop channel", {31'h0, ev_chan}, 32'h0);
        bus_rd(4'd2, 2'd0); check("R3", "active cleared", got_data, 32'h60);
        bus_rd(4'd0, 2'd0); check("R4", "dir kept on stop write", got_data, 32'h08);
        bus_wr(4'd0, 2'd0, 32'h00);
        bus_rd(4'd0, 2'd0); check("R4", "dir free when idle", got_data, 32'h00);
    endtask

    task automatic t_channel1();
        bus_wr(4'd12, 2'd2, 32'hABCD0003);
        bus_wr(4'd8, 2'd0, 32'h01);
        check("R1", "ch1 start pulse", {30'h0, ev_start, ev_stop}, 32'h2);
        check("R1", "ch1 event channel", {31'h0, ev_chan}, 32'h1);
        check("R1", "ch1 event pointer", ev_ptr, 32'hABCD0000);
        bus_rd(4'd8, 2'd2);  check("R1", "ch1 word at slice base", got_data, 32'h00610001);
        bus_rd(4'd2, 2'd0);  check("R1", "ch0 status untouched", got_data, 32'h60);
        bus_wr(4'd8, 2'd0, 32'h00);
        check("R1", "ch1 stop channel", {30'h0, ev_stop, ev_chan}, 32'h3);
    endtask

    task automatic t_read_widths();
        bus_rd(4'd2, 2'd1); check("R10", "half at 2", got_data, 32'h0060);
        check("R10", "read valid", {31'h0, got_valid}, 32'h1);
        bus_rd(4'd0, 2'd2); check("R10", "word at 0", got_data, 32'h00600000);
        bus_rd(4'd5, 2'd0); check("R10", "byte at 5", got_data, 32'h56);
        bus_rd(4'd6, 2'd1); check("R10", "half at 6", got_data, 32'h1234);
        bus_rd(4'd1, 2'd0); check("R1", "reserved byte 1", got_data, 32'h00);
    endtask

    task automatic t_w1c();
        @(negedge clk); dma_err_set = 2'b01; dma_irq_set = 2'b01;
        @(negedge clk); dma_err_set = 2'b00; dma_irq_set = 2'b00;
        bus_rd(4'd2, 2'd0);  check("R11", "err and irq set", got_data, 32'h66);
        bus_rd(4'd10, 2'd0); check("R11", "ch1 flags clear", got_data, 32'h60);
        bus_wr(4'd2, 2'd0, 32'h60);
        bus_rd(4'd2, 2'd0);  check("R11", "zero keeps flags", got_data, 32'h66);
        bus_wr(4'd2, 2'd0, 32'h62);
        bus_rd(4'd2, 2'd0);  check("R11", "clear err", got_data, 32'h64);
        bus_wr(4'd2, 2'd0, 32'h64);
        bus_rd(4'd2, 2'd0);  check("R11", "clear irq", got_data, 32'h60);
    endtask

    task automatic t_gates();
        bm_en = 1'b0;
        bus_wr(4'd0, 2'd0, 32'h01);
        check("R8", "no pulse without bm", {30'h0, ev_start, ev_stop}, 32'h0);
        bm_en = 1'b1;
        bus_rd(4'd0, 2'd0); check("R8", "control unchanged", got_data, 32'h00);
        io_en = 1'b0;
        bus_rd(4'd2, 2'd0); check("R9", "no read response", {31'h0, got_valid}, 32'h0);
        bus_wr(4'd0, 2'd0, 32'h01);
        check("R9", "no pulse without io", {30'h0, ev_start, ev_stop}, 32'h0);
        bus_wr(4'd0, 2'd1, 32'h01);
        io_en = 1'b1;
        bus_rd(4'd0, 2'd0); check("R9", "control unchanged", got_data, 32'h00);
        check("R9", "no error while disabled", {31'h0, size_err}, 32'h0);
    endtask

    task automatic t_bad_width();
        bus_wr(4'd0, 2'd1, 32'h0001);
        check("R6", "no pulse on half write", {30'h0, ev_start, ev_stop}, 32'h0);
        check("R12", "error set", {31'h0, size_err}, 32'h1);
        bus_rd(4'd0, 2'd0); check("R6", "control unchanged", got_data, 32'h00);
        bus_wr(4'd4, 2'd0, 32'hFF);
        bus_wr(4'd5, 2'd2, 32'hFFFFFFFF);
        bus_rd(4'd4, 2'd2); check("R6", "pointer unchanged", got_data, 32'h12345674);
        bus_wr(4'd2, 2'd2, 32'h0);
        bus_rd(4'd2, 2'd0); check("R12", "status unchanged", got_data, 32'h60);
        bus_rd(4'd1, 2'd1);
        check("R12", "bad read valid", {31'h0, got_valid}, 32'h1);
        check("R12", "bad read data", got_data, 32'h0);
        repeat (3) @(negedge clk);
        check("R12", "error sticky", {31'h0, size_err}, 32'h1);
    endtask

    initial begin
        for (int n = 0; n < 100000; n++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; io_en = 1'b1; bm_en = 1'b1;
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
        dma_err_set = '0; dma_irq_set = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_start();
        t_dir_lock();
        t_active_ro();
        t_stop();
        t_channel1();
        t_read_widths();
        t_w1c();
        t_gates();
        t_bad_width();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule